// File: doc/BRIEF.md
# Two-Class DMA Interrupt Status Unit

This unit collects the completion events of a DMA controller and turns them into one interrupt line for the processor. The controller has two classes of channels, normal and dedicated, with eight channels in each class. Every channel raises two single-cycle events: one when half of its transfer is done and one when the whole transfer is done. Each event sets a sticky bit in a 32-bit pending word. A 32-bit enable word masks which pending bits may raise the interrupt.

Software reaches both words through one 32-bit register port: a select line picks the word, `reg_rdata` always shows the selected word, and a write strobe loads it. A handler reads the pending word and writes that same value back. This clears only the events it has seen, so any event that arrives in the meantime stays pending. A driver that claims a channel sets that channel's end-of-transfer enable bit with a read-modify-write of the enable word. When it releases the channel, it clears the same bit.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, the pending word and the enable word both read as zero and `irq` is low.
- R2: An event on normal channel n sets pending bit 2n for half-transfer and bit 2n+1 for end-of-transfer, and the bit is visible on the cycle after the event.
- R3: An event on dedicated channel n sets pending bit 16+2n for half-transfer and bit 17+2n for end-of-transfer.
- R4: Events set pending bits whatever the enable word holds, and a pending bit stays set until it is cleared.
- R5: A write with `reg_sel`=0 (pending) clears each pending bit where the write data is 1 and leaves bits where it is 0 untouched. Writing back a value just read clears exactly those bits.
- R6: If an event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: A write with `reg_sel`=1 (enable) loads the enable word with the write data, and reading it returns that value. Writing zero masks every source, so `irq` drops.
- R8: `irq` is high exactly one cycle after a cycle in which some bit is set in both the pending word and the enable word.
- R9: Writing the enable word leaves the pending word unchanged. Writing the pending word never changes the enable word.
- R10: Writing all ones to the pending word clears every pending bit that has no event in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| norm_half | input | 8 | Half-transfer event pulses, normal channels |
| norm_end | input | 8 | End-of-transfer event pulses, normal channels |
| ded_half | input | 8 | Half-transfer event pulses, dedicated channels |
| ded_end | input | 8 | End-of-transfer event pulses, dedicated channels |
| reg_sel | input | 1 | Register select: 0 pending word, 1 enable word |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Selected word, combinational |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench aims at an event that lands in the same cycle as a clear of its own bit. A design that gives the clear priority would silently lose a completion there. It also replays the read-then-write-back handler sequence, which catches a design that clears whole words or inverts the write-one polarity. Events are raised with the enable word at zero, so a design that gates the pending bits by the enable shows a missing bit. Random traffic with both classes active at once checks the bit placement in both halves and the one-cycle delay of `irq`. A misplaced dedicated half would set the wrong bit, and a combinational `irq` would rise one cycle early.

// File: rtl/dis_pkg.sv
package dis_pkg;
    localparam int BITS_PER_CH = 2;   // half-transfer bit, then end-of-transfer bit
    localparam int HALF_OFS    = 0;
    localparam int END_OFS     = 1;

    typedef enum logic {
        SEL_PEND = 1'b0,
        SEL_EN   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/dis_evt_map.sv
module dis_evt_map #(
    parameter int NCH = 8,
    localparam int CLASS_W = NCH * dis_pkg::BITS_PER_CH,
    localparam int W = 2 * CLASS_W
) (
    input  logic [NCH-1:0] norm_half,
    input  logic [NCH-1:0] norm_end,
    input  logic [NCH-1:0] ded_half,
    input  logic [NCH-1:0] ded_end,
    output logic [W-1:0]   set_vec
);
    // Each channel owns a bit pair; the normal class fills the low half
    // of the word and the dedicated class fills the high half.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int BASE = ch * dis_pkg::BITS_PER_CH;
        assign set_vec[BASE + dis_pkg::HALF_OFS]           = norm_half[ch];
        assign set_vec[BASE + dis_pkg::END_OFS]            = norm_end[ch];
        assign set_vec[CLASS_W + BASE + dis_pkg::HALF_OFS] = ded_half[ch];
        assign set_vec[CLASS_W + BASE + dis_pkg::END_OFS]  = ded_end[ch];
    end
endmodule

// File: rtl/dis_pend_reg.sv
module dis_pend_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] pend
);
    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_wr ? clr_mask : '0;
    end

    // Event takes priority over a simultaneous clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_eff) | set_vec;
    end

    a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ((clr_mask & ~set_vec) != '0))
        |=> ((pend & $past(clr_mask & ~set_vec)) == '0));

    a_r9_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && (set_vec == '0)) |=> $stable(pend));
endmodule

// File: rtl/dis_en_reg.sv
module dis_en_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (wr) en <= wdata;
    end

    a_r7_en_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (en == $past(wdata)));

    a_r9_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(en));
endmodule

// File: rtl/dis_irq_out.sv
module dis_irq_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] en,
    output logic         irq
);
    logic any_hot;

    always_comb begin
        any_hot = |(pend & en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= any_hot;
    end

    a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
        any_hot |=> irq);

    a_r8_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hot |=> !irq);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
    parameter int NCH = 8,
    localparam int W = 2 * NCH * dis_pkg::BITS_PER_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] norm_half,
    input  logic [NCH-1:0] norm_end,
    input  logic [NCH-1:0] ded_half,
    input  logic [NCH-1:0] ded_end,
    input  logic           reg_sel,
    input  logic           reg_wr,
    input  logic [W-1:0]   reg_wdata,
    output logic [W-1:0]   reg_rdata,
    output logic           irq
);
    import dis_pkg::*;

    reg_sel_e     sel;
    logic [W-1:0] set_vec;
    logic [W-1:0] pend;
    logic [W-1:0] en;
    logic         wr_pend;
    logic         wr_en;

    always_comb begin
        sel     = reg_sel_e'(reg_sel);
        wr_pend = 1'b0;
        wr_en   = 1'b0;
        unique case (sel)
            SEL_PEND: begin
                wr_pend   = reg_wr;
                reg_rdata = pend;
            end
            SEL_EN: begin
                wr_en     = reg_wr;
                reg_rdata = en;
            end
            default: reg_rdata = '0;
        endcase
    end

    dis_evt_map #(.NCH(NCH)) u_map (
        .norm_half(norm_half),
        .norm_end (norm_end),
        .ded_half (ded_half),
        .ded_end  (ded_end),
        .set_vec  (set_vec)
    );

    dis_pend_reg #(.W(W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_wr  (wr_pend),
        .clr_mask(reg_wdata),
        .pend    (pend)
    );

    dis_en_reg #(.W(W)) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (wr_en),
        .wdata(reg_wdata),
        .en   (en)
    );

    dis_irq_out #(.W(W)) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .pend (pend),
        .en   (en),
        .irq  (irq)
    );

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && en == '0 && !irq));
endmodule

// File: tb/tb_dma_irq_status.sv
`timescale 1ns/1ps
module tb_dma_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  norm_half = '0, norm_end = '0, ded_half = '0, ded_end = '0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] m_pend = '0, m_en = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_status dut (
        .clk(clk), .rst_n(rst_n),
        .norm_half(norm_half), .norm_end(norm_end),
        .ded_half(ded_half), .ded_end(ded_end),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] ev_word(input logic [7:0] nh, ne, dh, de);
        logic [31:0] v = '0;
        for (int c = 0; c < 8; c++) begin
            v[2*c]      = nh[c];
            v[2*c+1]    = ne[c];
            v[16+2*c]   = dh[c];
            v[16+2*c+1] = de[c];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // One cycle: drive at negedge, check current state, update model, advance.
    task automatic step(input string tag, input logic [7:0] nh, ne, dh, de,
                        input logic sel, input logic wr, input logic [31:0] wd);
        logic [31:0] s;
        norm_half = nh; norm_end = ne; ded_half = dh; ded_end = de;
        reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        #1;
        chk({tag, " rdata"}, reg_rdata, sel ? m_en : m_pend);
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
        s = ev_word(nh, ne, dh, de);
        m_irq = |(m_pend & m_en);
        if (wr && !sel) m_pend = (m_pend & ~wd) | s;
        else            m_pend = m_pend | s;
        if (wr && sel)  m_en = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input logic sel);
        step(tag, 8'h0, 8'h0, 8'h0, 8'h0, sel, 1'b0, 32'h0);
    endtask

    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        summary();
    end

    initial begin
        logic [31:0] seen;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of both words and irq
        idle("R1 pend", 1'b0);
        idle("R1 en", 1'b1);
        // R2 / R4: normal ch3 half, ch6 end with enable still zero
        step("R2 event", 8'h08, 8'h40, 8'h0, 8'h0, 1'b0, 1'b0, 0);
        chk("R2 map", m_pend, 32'h0000_2040);
        idle("R2 read", 1'b0);
        idle("R4 masked irq", 1'b0);
        // R3: dedicated ch5 end and ch0 half
        step("R3 event", 8'h0, 8'h0, 8'h01, 8'h20, 1'b0, 1'b0, 0);
        chk("R3 map", m_pend, 32'h0801_2040);
        idle("R3 read", 1'b0);
        // R9: enable write leaves pending; R8 irq follows one cycle later
        step("R9 en write", 8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b1, 32'h0800_0000);
        idle("R8 irq pre", 1'b0);
        idle("R8 irq high", 1'b1);
        // R5: handler write-back of observed value, new event arrives meanwhile
        seen = m_pend;
        step("R5 writeback", 8'h0, 8'h02, 8'h0, 8'h0, 1'b0, 1'b1, seen);
        chk("R5 model", m_pend, 32'h0000_0008);
        idle("R5 read", 1'b0);
        idle("R8 irq low", 1'b0);
        // R6: event and clear on the same bit in the same cycle
        step("R6 collide", 8'h0, 8'h02, 8'h0, 8'h0, 1'b0, 1'b1, 32'h0000_0008);
        idle("R6 read", 1'b0);
        // R10: all-ones clear; R9 enable untouched by pending write
        step("R10 fill", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 0);
        step("R10 clear", 8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b1, 32'hFFFF_FFFF);
        idle("R10 read", 1'b0);
        idle("R9 en kept", 1'b1);
        // R7: read-modify-write of one end enable, then zero masks all
        step("R7 rmw", 8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b1, m_en | 32'h0000_0002);
        idle("R7 read", 1'b1);
        step("R7 ev", 8'h0, 8'h01, 8'h0, 8'h0, 1'b0, 1'b0, 0);
        idle("R7 irq on", 1'b0);
        step("R7 zero", 8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b1, 32'h0);
        idle("R7 masked", 1'b1);
        idle("R7 irq off", 1'b0);
        // Random traffic over every requirement
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a, b, c, d;
            logic s, w;
            logic [31:0] wd;
            a = 8'($urandom & $urandom & $urandom);
            b = 8'($urandom & $urandom & $urandom);
            c = 8'($urandom & $urandom & $urandom);
            d = 8'($urandom & $urandom & $urandom);
            s = 1'($urandom);
            w = ($urandom % 4) == 0;
            wd = (!s && ($urandom % 2)) ? m_pend : $urandom;
            step("R8 rand", a, b, c, d, s, w, wd);
        end
        summary();
    end
endmodule